// File: doc/BRIEF.md
# System Call Trap Entry Unit

This unit saves architectural state when a system call instruction retires. A single-cycle strobe presents the address of the retiring instruction, the current 64-bit machine state word and a select between the two call forms, ordinary and vectored. On the next clock edge the unit records the return address, a masked image of the machine state, the replacement machine state and the address from which fetch resumes.

The two forms put the return address in different places. The ordinary form writes it to the return-address save register and resumes fetch at a fixed trap offset. The vectored form writes it to the link register, leaves the save register alone, and resumes fetch at an address supplied on an input. Both forms write the same saved-status image, in which only some machine-state fields are kept and the rest are forced to zero. Both forms load the replacement machine state, which is chosen outside this unit and presented on an input. Between strobes every output holds its value.

Bit numbers in the requirements count from the most significant end: bit 0 of a 64-bit word is bus index 63, and bit k is bus index 63-k.

Top module: `sct_entry`

## Requirements
- R1: After reset every data output is zero and both write pulses are low.
- R2: An ordinary-form strobe (`call_vec_i` = 0) loads `ret_save_o` with `cia_i` + 4 on the next edge and leaves `link_o` unchanged.
- R3: A vectored-form strobe (`call_vec_i` = 1) loads `link_o` with `cia_i` + 4 on the next edge and leaves `ret_save_o` unchanged.
- R4: On a strobe of either form, `stat_save_o` bits 0-32, 37-41 and 48-63 equal the same bit positions of `msr_i`.
- R5: `stat_save_o` bits 33-36 and 42-47 (bus mask 64'h0000_0000_783F_0000) are zero for both forms, whatever `msr_i` holds.
- R6: On a strobe, `next_pc_o` becomes the `ORD_VECTOR` parameter (default 64'hC00) for the ordinary form and `vec_addr_i` for the vectored form.
- R7: On a strobe of either form, `msr_o` becomes `new_msr_i`.
- R8: While `take_i` is low, all data outputs keep their values, whatever the other inputs do.
- R9: `wr_save_o` is high for exactly the cycle after an ordinary-form strobe and `wr_link_o` for exactly the cycle after a vectored-form strobe. They are never high together.
- R10: Return-address formation wraps modulo 2^64, so `cia_i` = 64'hFFFF_FFFF_FFFF_FFFC gives a return address of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| take_i | input | 1 | One-cycle strobe: a system call retires |
| call_vec_i | input | 1 | 0 selects the ordinary form, 1 the vectored form |
| cia_i | input | 64 | Address of the retiring instruction |
| msr_i | input | 64 | Current machine state word |
| new_msr_i | input | 64 | Replacement machine state chosen by policy |
| vec_addr_i | input | 64 | Fetch target for the vectored form |
| ret_save_o | output | 64 | Return-address save register |
| stat_save_o | output | 64 | Saved-status register image |
| link_o | output | 64 | Link register value |
| msr_o | output | 64 | Machine state after the call |
| next_pc_o | output | 64 | Address from which fetch resumes |
| wr_save_o | output | 1 | Pulse: the save registers were written by an ordinary call |
| wr_link_o | output | 1 | Pulse: the link register was written by a vectored call |

## Verification
The assertions assume that `call_vec_i` and the data inputs are settled whenever `take_i` is high, and that `take_i` carries no unknown value out of reset. The bench changes every input only at the falling clock edge, so each value is stable across the rising edge that captures it. Between strobes the bench also changes the data inputs, to show that they are ignored. Machine-state values come from all-zero, all-one, walking-bit and random patterns, so that every kept and every cleared bit position is exercised for both call forms.

// File: rtl/sct_pkg.sv
package sct_pkg;

  localparam int XLEN = 64;

  typedef enum logic {
    CALL_ORD = 1'b0,
    CALL_VEC = 1'b1
  } call_kind_e;

  // Bit k in MSB-first numbering sits at bus index XLEN-1-k.
  function automatic logic [XLEN-1:0] stat_keep_mask();
    logic [XLEN-1:0] m;
    m = '0;
    for (int k = 0; k < XLEN; k++) begin
      if ((k <= 32) || ((k >= 37) && (k <= 41)) || (k >= 48))
        m[XLEN-1-k] = 1'b1;
    end
    return m;
  endfunction

  typedef struct packed {
    logic [XLEN-1:0] ret_save;
    logic [XLEN-1:0] stat_save;
    logic [XLEN-1:0] link;
    logic [XLEN-1:0] msr;
    logic [XLEN-1:0] next_pc;
    logic            wr_save;
    logic            wr_link;
  } sct_state_t;

endpackage

// File: rtl/sct_image.sv
module sct_image
  import sct_pkg::*;
(
  input  logic [XLEN-1:0] msr_i,
  output logic [XLEN-1:0] img_o
);

  localparam logic [XLEN-1:0] KEEP = stat_keep_mask();

  // Kept fields copy straight through; holes are driven to zero.
  always_comb begin
    img_o = '0;
    for (int b = 0; b < XLEN; b++) begin
      if (KEEP[b]) img_o[b] = msr_i[b];
    end
  end

endmodule

// File: rtl/sct_addr.sv
module sct_addr
  import sct_pkg::*;
#(
  parameter int              IA_W       = XLEN,
  parameter int              STEP       = 4,
  parameter logic [IA_W-1:0] ORD_VECTOR = IA_W'(64'hC00)
) (
  input  call_kind_e      kind_i,
  input  logic [IA_W-1:0] cia_i,
  input  logic [IA_W-1:0] vec_addr_i,
  output logic [IA_W-1:0] ret_o,
  output logic [IA_W-1:0] target_o
);

  localparam logic [IA_W-1:0] STEP_V = IA_W'(STEP);

  always_comb begin
    ret_o = cia_i + STEP_V;
  end

  always_comb begin
    unique case (kind_i)
      CALL_VEC: target_o = vec_addr_i;
      default:  target_o = ORD_VECTOR;
    endcase
  end

endmodule

// File: rtl/sct_regs.sv
module sct_regs
  import sct_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  call_kind_e      kind_i,
  input  logic [XLEN-1:0] ret_i,
  input  logic [XLEN-1:0] img_i,
  input  logic [XLEN-1:0] new_msr_i,
  input  logic [XLEN-1:0] target_i,
  output sct_state_t      st_o
);

  localparam logic [XLEN-1:0] HOLES = ~stat_keep_mask();

  sct_state_t st_q, st_d;
  logic       en_save, en_link, en_common;

  always_comb begin
    en_common = take_i;
    en_save   = take_i && (kind_i == CALL_ORD);
    en_link   = take_i && (kind_i == CALL_VEC);
  end

  always_comb begin
    st_d         = st_q;
    st_d.wr_save = en_save;
    st_d.wr_link = en_link;
    if (en_save)   st_d.ret_save = ret_i;
    if (en_link)   st_d.link     = ret_i;
    if (en_common) begin
      st_d.stat_save = img_i;
      st_d.msr       = new_msr_i;
      st_d.next_pc   = target_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign st_o = st_q;

  // R5
  holes_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.stat_save & HOLES) == '0);

  // R9
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({st_q.wr_save, st_q.wr_link}));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !take_i |=> ($stable(st_q.ret_save) && $stable(st_q.link) &&
                 $stable(st_q.stat_save) && $stable(st_q.msr) &&
                 $stable(st_q.next_pc)));

endmodule

// File: rtl/sct_entry.sv
module sct_entry
  import sct_pkg::*;
#(
  parameter logic [XLEN-1:0] ORD_VECTOR = 64'hC00
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take_i,
  input  logic            call_vec_i,
  input  logic [XLEN-1:0] cia_i,
  input  logic [XLEN-1:0] msr_i,
  input  logic [XLEN-1:0] new_msr_i,
  input  logic [XLEN-1:0] vec_addr_i,
  output logic [XLEN-1:0] ret_save_o,
  output logic [XLEN-1:0] stat_save_o,
  output logic [XLEN-1:0] link_o,
  output logic [XLEN-1:0] msr_o,
  output logic [XLEN-1:0] next_pc_o,
  output logic            wr_save_o,
  output logic            wr_link_o
);

  call_kind_e      kind;
  logic [XLEN-1:0] img, ret, target;
  sct_state_t      st;

  assign kind = call_vec_i ? CALL_VEC : CALL_ORD;

  sct_image u_image (
    .msr_i (msr_i),
    .img_o (img)
  );

  sct_addr #(
    .IA_W       (XLEN),
    .STEP       (4),
    .ORD_VECTOR (ORD_VECTOR)
  ) u_addr (
    .kind_i     (kind),
    .cia_i      (cia_i),
    .vec_addr_i (vec_addr_i),
    .ret_o      (ret),
    .target_o   (target)
  );

  sct_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .take_i    (take_i),
    .kind_i    (kind),
    .ret_i     (ret),
    .img_i     (img),
    .new_msr_i (new_msr_i),
    .target_i  (target),
    .st_o      (st)
  );

  assign ret_save_o  = st.ret_save;
  assign stat_save_o = st.stat_save;
  assign link_o      = st.link;
  assign msr_o       = st.msr;
  assign next_pc_o   = st.next_pc;
  assign wr_save_o   = st.wr_save;
  assign wr_link_o   = st.wr_link;

  // R2
  ord_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !call_vec_i) |=> (ret_save_o == $past(cia_i) + 64'd4) && $stable(link_o));

  // R3
  vec_ret_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && call_vec_i) |=> (link_o == $past(cia_i) + 64'd4) && $stable(ret_save_o));

  // R6
  vec_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && call_vec_i) |=> (next_pc_o == $past(vec_addr_i)));

  // R6
  ord_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take_i && !call_vec_i) |=> (next_pc_o == ORD_VECTOR));

  // R7
  msr_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_i |=> (msr_o == $past(new_msr_i)));

  // R9
  save_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_save_o |-> $past(take_i && !call_vec_i));

endmodule

// File: tb/sct_entry_bench.sv
`timescale 1ns/1ps
module sct_entry_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        take_i = 1'b0;
  logic        call_vec_i = 1'b0;
  logic [63:0] cia_i = '0, msr_i = '0, new_msr_i = '0, vec_addr_i = '0;
  logic [63:0] ret_save_o, stat_save_o, link_o, msr_o, next_pc_o;
  logic        wr_save_o, wr_link_o;

  int checks = 0;
  int fails  = 0;
  logic [63:0] keep;

  always #2.5 clk = ~clk;

  sct_entry u_sct_entry (
    .clk(clk), .rst_n(rst_n), .take_i(take_i), .call_vec_i(call_vec_i),
    .cia_i(cia_i), .msr_i(msr_i), .new_msr_i(new_msr_i), .vec_addr_i(vec_addr_i),
    .ret_save_o(ret_save_o), .stat_save_o(stat_save_o), .link_o(link_o),
    .msr_o(msr_o), .next_pc_o(next_pc_o), .wr_save_o(wr_save_o), .wr_link_o(wr_link_o)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Strobe one call, then sample at the following falling edge.
  task automatic fire(input logic vec, input logic [63:0] cia, input logic [63:0] msr,
                      input logic [63:0] nmsr, input logic [63:0] va);
    call_vec_i = vec; cia_i = cia; msr_i = msr; new_msr_i = nmsr; vec_addr_i = va;
    take_i = 1'b1;
    @(negedge clk);
    take_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 ret_save", ret_save_o, 64'h0);
    chk("R1 stat_save", stat_save_o, 64'h0);
    chk("R1 link", link_o, 64'h0);
    chk("R1 msr", msr_o, 64'h0);
    chk("R1 next_pc", next_pc_o, 64'h0);
    chk("R1 pulses", {62'h0, wr_save_o, wr_link_o}, 64'h0);
  endtask

  task automatic t_ordinary();
    logic [63:0] lk;
    lk = link_o;
    fire(1'b0, 64'h0000_1000_0000_2000, 64'hFFFF_FFFF_FFFF_FFFF, 64'h8000_0000_0000_1001, 64'hDEAD);
    chk("R2 ret_save", ret_save_o, 64'h0000_1000_0000_2004);
    chk("R2 link kept", link_o, lk);
    chk("R4 ones image", stat_save_o, 64'hFFFF_FFFF_87C0_FFFF);
    chk("R6 ordinary target", next_pc_o, 64'hC00);
    chk("R7 msr ord", msr_o, 64'h8000_0000_0000_1001);
    chk("R9 wr_save", {63'h0, wr_save_o}, 64'h1);
    chk("R9 wr_link low", {63'h0, wr_link_o}, 64'h0);
    @(negedge clk);
    chk("R9 wr_save single", {63'h0, wr_save_o}, 64'h0);
  endtask

  task automatic t_vectored();
    logic [63:0] rs;
    rs = ret_save_o;
    fire(1'b1, 64'h0000_0000_0040_0100, 64'h0000_0000_783F_0000, 64'h1234_5678_9ABC_DEF0, 64'h0000_0000_0001_7000);
    chk("R3 link", link_o, 64'h0000_0000_0040_0104);
    chk("R3 ret_save kept", ret_save_o, rs);
    chk("R5 holes only", stat_save_o, 64'h0);
    chk("R6 vec target", next_pc_o, 64'h0000_0000_0001_7000);
    chk("R7 msr vec", msr_o, 64'h1234_5678_9ABC_DEF0);
    chk("R9 wr_link", {63'h0, wr_link_o}, 64'h1);
    chk("R9 wr_save low", {63'h0, wr_save_o}, 64'h0);
  endtask

  task automatic t_hold();
    logic [63:0] a, b, c, d, e;
    a = ret_save_o; b = stat_save_o; c = link_o; d = msr_o; e = next_pc_o;
    call_vec_i = 1'b0; cia_i = 64'h5555; msr_i = 64'hAAAA_AAAA_AAAA_AAAA;
    new_msr_i = 64'h7777; vec_addr_i = 64'h9999;
    repeat (3) @(negedge clk);
    call_vec_i = 1'b1;
    @(negedge clk);
    chk("R8 ret_save", ret_save_o, a);
    chk("R8 stat_save", stat_save_o, b);
    chk("R8 link", link_o, c);
    chk("R8 msr", msr_o, d);
    chk("R8 next_pc", next_pc_o, e);
  endtask

  task automatic t_wrap();
    fire(1'b0, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0, 64'h0);
    chk("R10 wrap ord", ret_save_o, 64'h0);
    fire(1'b1, 64'hFFFF_FFFF_FFFF_FFFC, 64'h0, 64'h0, 64'h0);
    chk("R10 wrap vec", link_o, 64'h0);
  endtask

  task automatic t_walk();
    for (int k = 0; k < 64; k++) begin
      logic [63:0] m;
      m = 64'h1 << (63 - k);
      fire(k[0], 64'h100, m, 64'h0, 64'h200);
      chk(((k >= 33 && k <= 36) || (k >= 42 && k <= 47)) ? "R5 walk hole" : "R4 walk kept",
          stat_save_o, m & keep);
    end
  endtask

  task automatic t_random();
    for (int n = 0; n < 40; n++) begin
      logic [63:0] m, c, nm, va;
      logic v;
      m  = {$urandom, $urandom};
      c  = {$urandom, $urandom} & ~64'h3;
      nm = {$urandom, $urandom};
      va = {$urandom, $urandom};
      v  = n[0];
      fire(v, c, m, nm, va);
      chk("R4 random image", stat_save_o, m & keep);
      chk("R7 random msr", msr_o, nm);
      if (v) chk("R3 random link", link_o, c + 64'd4);
      else   chk("R2 random save", ret_save_o, c + 64'd4);
    end
  endtask

  initial begin : watchdog
    #400000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    keep = '0;
    for (int k = 0; k < 64; k++)
      if (!((k >= 33 && k <= 36) || (k >= 42 && k <= 47))) keep[63 - k] = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ordinary();
    t_vectored();
    t_hold();
    t_wrap();
    t_walk();
    t_random();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule